// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a behavioural, synthesizable model of one programmable logic cell of the kind tiled across a reconfigurable fabric. A static configuration set on its inputs holds the lookup-table contents, the operating mode, the cascade operator, the register source and the routing of the two outputs. Each cell takes four data inputs, a ripple carry and a cascade input. It produces a carry and a cascade result for the next cell, plus two outputs that are selected separately: one for nearby routing and one for long-distance routing.

The cell has three modes. In general mode a 16-entry table evaluates any function of four inputs, and the carry can stand in for the third data input. In arithmetic mode the table splits into two 8-entry halves. Both halves are indexed by the carry and the two low data inputs: one half gives the sum and the other gives the carry to the next cell. In counter mode a fixed datapath forms one bit of an up/down counter. That datapath has a count enable, a direction, a synchronous load and a ripple carry. The storage flop can take a data input directly instead of the function result ("packing"), so that the table and the flop serve unrelated logic.

Cells are joined by wiring the carry and cascade outputs of one cell to the inputs of the next. The head of a cascade chain is given the identity value of the chosen operator: 1 for AND, 0 for OR.

Top module: `lcell_core`

## Requirements
- R1: In general mode (cfg_mode = 0, also 3), the function value is cfg_lut[idx], where idx = {data_in[3], data_in[2], data_in[1], data_in[0]}. When cfg_carry_sel = 1, carry_in takes the place of data_in[2] in idx. carry_out is 0 in this mode.
- R2: casc_out is the function value combined with casc_in: AND when cfg_casc_or = 0, OR when cfg_casc_or = 1. Chained cells give a wide decode.
- R3: In arithmetic mode (cfg_mode = 1), with k = {carry_in, data_in[1], data_in[0]}, the function value is cfg_lut[k] and carry_out is cfg_lut[8 + k]. data_in[3:2] have no effect.
- R4: In arithmetic mode the sum also passes through the cascade combine of R2.
- R5: local_out shows casc_out when cfg_local_reg = 0 and the flop when cfg_local_reg = 1. global_out makes the same choice on its own from cfg_global_reg. The two outputs may make different choices.
- R6: Outside counter mode the flop captures casc_out when cfg_pack = 0 and data_in[3] when cfg_pack = 1. The function output is unaffected by cfg_pack.
- R7: While ena = 0 the flop keeps its value on clock edges. This includes a counter load.
- R8: clr forces the flop to 0 immediately, without a clock. pre forces it to 1 immediately. When both are high, clr wins.
- R9: In counter mode (cfg_mode = 2) the data inputs have these meanings: data_in[3] is count enable, data_in[2] is synchronous load, data_in[1] is direction (1 = up), data_in[0] is load value. The next flop value is the load value when load = 1. Otherwise it is q XOR carry_in when enabled, and q when not. carry_out is carry_in AND q when counting up, and carry_in AND NOT q when counting down.
- R10: A clock edge with rst_n = 0 clears the flop. This synchronous reset ranks below clr and pre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flop |
| cfg_lut | input | 16 | Lookup-table contents |
| cfg_mode | input | 2 | 0 general, 1 arithmetic, 2 counter, 3 as general |
| cfg_carry_sel | input | 1 | General mode: carry_in replaces data_in[2] in the table index |
| cfg_casc_or | input | 1 | Cascade operator: 0 AND, 1 OR |
| cfg_pack | input | 1 | Flop takes data_in[3] directly (outside counter mode) |
| cfg_local_reg | input | 1 | local_out source: 0 combinational, 1 flop |
| cfg_global_reg | input | 1 | global_out source: 0 combinational, 1 flop |
| data_in | input | 4 | Data inputs |
| carry_in | input | 1 | Carry from the previous cell |
| casc_in | input | 1 | Cascade from the previous cell |
| ena | input | 1 | Clock enable |
| clr | input | 1 | Asynchronous clear |
| pre | input | 1 | Asynchronous preset |
| carry_out | output | 1 | Carry to the next cell |
| casc_out | output | 1 | Cascade result to the next cell |
| local_out | output | 1 | Output to nearby routing |
| global_out | output | 1 | Output to long-distance routing |

## Verification
The assertions check the following on every cycle: the cascade result against the operator's dominant input value, the carry being 0 in general mode, the effect of clear and preset and the priority between them, the flop holding while the clock enable is low, the counter load, and the synchronous reset. Only the bench's scenarios can show the rest. That includes the full table contents in both index forms, the split sum and carry tables with their ignored inputs, and independent routing of the two outputs. It also includes packed operation, and a two-cell counter that counts up, counts down, loads and holds across its ripple carry.

// File: rtl/lcell_pkg.sv
// Package: shared mode type and counter-mode field positions of the logic cell.
// Assumes data_in is at least four bits wide.
package lcell_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_ARITH  = 2'd1,
        MODE_COUNT  = 2'd2,
        MODE_SPARE  = 2'd3
    } cell_mode_e;

    // Meaning of data_in bits in counter mode.
    localparam int CNT_LDVAL = 0;
    localparam int CNT_UP    = 1;
    localparam int CNT_LOAD  = 2;
    localparam int CNT_EN    = 3;

endpackage

// File: rtl/lcell_func.sv
// Module: lcell_func
// Combinational core of the cell. It evaluates the lookup table as one
// full-width table (general mode) or as two half tables (arithmetic mode),
// or it forms the counter next-state bit and the ripple carry.
// Assumes NUM_IN >= 4 and a static configuration.
module lcell_func
    import lcell_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int LUT_BITS = 1 << NUM_IN
) (
    input  logic [LUT_BITS-1:0] cfg_lut,
    input  cell_mode_e          mode,
    input  logic                carry_sel,
    input  logic [NUM_IN-1:0]   data_in,
    input  logic                carry_in,
    input  logic                reg_q,
    output logic                func_o,
    output logic                carry_o
);

    localparam int SEL_POS = NUM_IN - 2;

    logic [NUM_IN-1:0] full_idx;
    logic [NUM_IN-2:0] half_idx;
    logic              cnt_next;
    logic              cnt_carry;

    // Build the full and half table indices.
    always_comb begin
        full_idx = data_in;
        if (carry_sel) begin
            full_idx[SEL_POS] = carry_in;
        end
        half_idx = {carry_in, data_in[NUM_IN-3:0]};
    end

    // Counter datapath: load mux ahead of the toggle, and the direction-aware carry.
    always_comb begin
        if (data_in[CNT_LOAD]) begin
            cnt_next = data_in[CNT_LDVAL];
        end else if (data_in[CNT_EN]) begin
            cnt_next = reg_q ^ carry_in;
        end else begin
            cnt_next = reg_q;
        end
        cnt_carry = carry_in & (data_in[CNT_UP] ? reg_q : ~reg_q);
    end

    // Select the function value and the carry for the configured mode.
    always_comb begin
        unique case (mode)
            MODE_ARITH: begin
                func_o  = cfg_lut[{1'b0, half_idx}];
                carry_o = cfg_lut[{1'b1, half_idx}];
            end
            MODE_COUNT: begin
                func_o  = cnt_next;
                carry_o = cnt_carry;
            end
            default: begin
                func_o  = cfg_lut[full_idx];
                carry_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lcell_casc.sv
// Module: lcell_casc
// Combines the cell's function value with the incoming cascade using the
// configured operator. The head of a chain is assumed to be given the
// operator's identity value (1 for AND, 0 for OR).
module lcell_casc (
    input  logic func_i,
    input  logic casc_in,
    input  logic use_or,
    output logic casc_out
);

    // Apply the AND or OR cascade operator.
    always_comb begin
        casc_out = use_or ? (func_i | casc_in) : (func_i & casc_in);
    end

endmodule

// File: rtl/lcell_reg.sv
// Module: lcell_reg
// Storage flop of the cell. It has asynchronous clear and preset (clear
// wins), a synchronous active-low reset and a clock enable. Assumes clr and
// pre are not released in the same instant one of them is still needed.
module lcell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pre,
    input  logic ena,
    input  logic d,
    output logic q
);

    // Async clear/preset, then sync reset, then enabled capture.
    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr) begin
            q <= 1'b0;
        end else if (pre) begin
            q <= 1'b1;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (ena) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lcell_core.sv
// Module: lcell_core (top)
// One configurable logic cell. It has general, arithmetic and counter modes,
// carry and cascade chaining, register packing and two independently routed
// outputs. Configuration inputs are assumed static during operation.
module lcell_core
    import lcell_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int LUT_BITS = 1 << NUM_IN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LUT_BITS-1:0] cfg_lut,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_carry_sel,
    input  logic                cfg_casc_or,
    input  logic                cfg_pack,
    input  logic                cfg_local_reg,
    input  logic                cfg_global_reg,
    input  logic [NUM_IN-1:0]   data_in,
    input  logic                carry_in,
    input  logic                casc_in,
    input  logic                ena,
    input  logic                clr,
    input  logic                pre,
    output logic                carry_out,
    output logic                casc_out,
    output logic                local_out,
    output logic                global_out
);

    localparam int PACK_BIT = NUM_IN - 1;

    cell_mode_e mode;
    logic       func_val;
    logic       reg_d;
    logic       reg_q;

    assign mode = cell_mode_e'(cfg_mode);

    lcell_func #(
        .NUM_IN   (NUM_IN),
        .LUT_BITS (LUT_BITS)
    ) u_func (
        .cfg_lut   (cfg_lut),
        .mode      (mode),
        .carry_sel (cfg_carry_sel),
        .data_in   (data_in),
        .carry_in  (carry_in),
        .reg_q     (reg_q),
        .func_o    (func_val),
        .carry_o   (carry_out)
    );

    lcell_casc u_casc (
        .func_i   (func_val),
        .casc_in  (casc_in),
        .use_or   (cfg_casc_or),
        .casc_out (casc_out)
    );

    // Pick the flop input: counter next state, packed data bit, or cascade result.
    always_comb begin
        if (mode == MODE_COUNT) begin
            reg_d = func_val;
        end else if (cfg_pack) begin
            reg_d = data_in[PACK_BIT];
        end else begin
            reg_d = casc_out;
        end
    end

    lcell_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .pre   (pre),
        .ena   (ena),
        .d     (reg_d),
        .q     (reg_q)
    );

    // Route each output from the combinational path or the flop, independently.
    always_comb begin
        local_out  = cfg_local_reg  ? reg_q : casc_out;
        global_out = cfg_global_reg ? reg_q : casc_out;
    end

endmodule

// File: rtl/lcell_core_chk.sv
// Module: lcell_core_chk
// Property checker for lcell_core, attached through bind. It assumes
// asynchronous clr/pre pulses are held across at least one rising clock edge.
module lcell_core_chk
    import lcell_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_casc_or,
    input logic       casc_in,
    input logic       casc_out,
    input logic       carry_out,
    input logic       ena,
    input logic       clr,
    input logic       pre,
    input logic       load_req,
    input logic       load_val,
    input logic       reg_q
);

    AST_NORMAL_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_NORMAL) |-> !carry_out); // R1

    AST_CASC_AND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_casc_or && !casc_in) |-> !casc_out); // R2

    AST_CASC_OR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_casc_or && casc_in) |-> casc_out); // R2

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !reg_q); // R8

    AST_PRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr) |-> reg_q); // R8

    AST_HOLD_NO_ENA: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena && !clr && !pre) |=> (clr || pre || $stable(reg_q))); // R7

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == MODE_COUNT) && ena && load_req && !clr && !pre)
        |=> (clr || pre || (reg_q == $past(load_val)))); // R9

    AST_SYNC_RESET: assert property (@(posedge clk)
        (!rst_n && !clr && !pre) |=> (clr || pre || !reg_q)); // R10

endmodule

bind lcell_core lcell_core_chk chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_casc_or (cfg_casc_or),
    .casc_in     (casc_in),
    .casc_out    (casc_out),
    .carry_out   (carry_out),
    .ena         (ena),
    .clr         (clr),
    .pre         (pre),
    .load_req    (data_in[lcell_pkg::CNT_LOAD]),
    .load_val    (data_in[lcell_pkg::CNT_LDVAL]),
    .reg_q       (reg_q)
);

// File: tb/lcell_core_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios on a two-cell chain. uut is the head cell and
// cell1 follows it through carry and cascade.
module lcell_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lut0 = 16'h0;
    logic [15:0] lut1 = 16'h0;
    logic [1:0]  mode = 2'd0;
    logic        csel = 1'b0, cor = 1'b0, pack = 1'b0, lreg = 1'b0, greg = 1'b0;
    logic [3:0]  d0 = 4'h0, d1 = 4'h0;
    logic        cin0 = 1'b0, casc0 = 1'b1, ena = 1'b1, clr = 1'b0, pre = 1'b0;
    logic        cout0, cc0, l0, g0, cout1, cc1, l1, g1;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    lcell_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_lut(lut0), .cfg_mode(mode),
        .cfg_carry_sel(csel), .cfg_casc_or(cor), .cfg_pack(pack),
        .cfg_local_reg(lreg), .cfg_global_reg(greg), .data_in(d0),
        .carry_in(cin0), .casc_in(casc0), .ena(ena), .clr(clr), .pre(pre),
        .carry_out(cout0), .casc_out(cc0), .local_out(l0), .global_out(g0)
    );

    lcell_core cell1 (
        .clk(clk), .rst_n(rst_n), .cfg_lut(lut1), .cfg_mode(mode),
        .cfg_carry_sel(csel), .cfg_casc_or(cor), .cfg_pack(pack),
        .cfg_local_reg(lreg), .cfg_global_reg(greg), .data_in(d1),
        .carry_in(cout0), .casc_in(cc0), .ena(ena), .clr(clr), .pre(pre),
        .carry_out(cout1), .casc_out(cc1), .local_out(l1), .global_out(g1)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        lreg = 1'b1;
        #1;
        chk("R10 reset state cell0", l0, 1'b0);
        chk("R10 reset state cell1", l1, 1'b0);
    endtask

    task automatic t_normal();
        @(negedge clk);
        mode = 2'd0; lut0 = 16'hB4E1; casc0 = 1'b1; cor = 1'b0;
        lreg = 1'b0; greg = 1'b0; csel = 1'b0; pack = 1'b0;
        for (int i = 0; i < 16; i++) begin
            d0 = 4'(i); cin0 = ~d0[2];
            #1;
            chk("R1 table lookup", l0, lut0[i]);
            chk("R1 carry zero", cout0, 1'b0);
        end
        csel = 1'b1;
        for (int i = 0; i < 16; i++) begin
            d0 = 4'(i); cin0 = ~d0[2];
            #1;
            chk("R1 carry as index bit 2", l0, lut0[i ^ 4]);
        end
        csel = 1'b0;
    endtask

    task automatic t_cascade();
        @(negedge clk);
        mode = 2'd0; lreg = 1'b0; cor = 1'b0; casc0 = 1'b1;
        lut0 = 16'h8000; lut1 = 16'h0001;
        d0 = 4'hF; d1 = 4'h0; #1;
        chk("R2 AND chain match", cc1, 1'b1);
        d0 = 4'hE; #1;
        chk("R2 AND chain head miss", cc1, 1'b0);
        d0 = 4'hF; d1 = 4'h1; #1;
        chk("R2 AND chain tail miss", cc1, 1'b0);
        cor = 1'b1; casc0 = 1'b0;
        d0 = 4'hE; d1 = 4'h1; #1;
        chk("R2 OR chain none", cc1, 1'b0);
        d0 = 4'hF; #1;
        chk("R2 OR chain head hit", cc1, 1'b1);
        d0 = 4'h0; d1 = 4'h0; #1;
        chk("R2 OR chain tail hit", cc1, 1'b1);
        cor = 1'b0; casc0 = 1'b1;
    endtask

    task automatic t_arith();
        logic [2:0] k;
        @(negedge clk);
        mode = 2'd1; lut0 = 16'hE896; cor = 1'b0; casc0 = 1'b1; lreg = 1'b0;
        for (int i = 0; i < 8; i++) begin
            k = 3'(i);
            d0 = {k[1] ^ k[0], ~k[2], k[1], k[0]};
            cin0 = k[2];
            #1;
            chk("R3 sum", l0, ^k);
            chk("R3 carry", cout0, (k[0] & k[1]) | (k[2] & (k[0] | k[1])));
        end
        d0 = 4'b0001; cin0 = 1'b0; casc0 = 1'b0; #1;
        chk("R4 sum blocked by AND cascade", l0, 1'b0);
        casc0 = 1'b1; #1;
        chk("R4 sum through AND cascade", l0, 1'b1);
        d0 = 4'b0000; cor = 1'b1; #1;
        chk("R4 OR cascade forces one", l0, 1'b1);
        cor = 1'b0;
    endtask

    task automatic t_pack();
        @(negedge clk);
        mode = 2'd0; lut0 = 16'h0000; casc0 = 1'b1; cor = 1'b0;
        pack = 1'b1; lreg = 1'b0; greg = 1'b1; ena = 1'b1; d0 = 4'b1000;
        step();
        chk("R6 packed flop takes data bit 3", g0, 1'b1);
        chk("R6 table output independent", l0, 1'b0);
        pack = 1'b0;
        step();
        chk("R6 unpacked flop takes function", g0, 1'b0);
        lut0 = 16'hFFFF; casc0 = 1'b0;
        step();
        chk("R6 flop takes cascade result", g0, 1'b0);
        casc0 = 1'b1;
        step();
        chk("R6 flop takes cascade pass", g0, 1'b1);
    endtask

    task automatic t_route();
        @(negedge clk);
        mode = 2'd0; lut0 = 16'hFFFF; casc0 = 1'b1; pack = 1'b1; d0 = 4'b0000;
        ena = 1'b1;
        step();
        lreg = 1'b0; greg = 1'b1; #1;
        chk("R5 local comb", l0, 1'b1);
        chk("R5 global flop", g0, 1'b0);
        lreg = 1'b1; greg = 1'b0; #1;
        chk("R5 local flop", l0, 1'b0);
        chk("R5 global comb", g0, 1'b1);
        pack = 1'b0;
    endtask

    task automatic t_enable();
        @(negedge clk);
        mode = 2'd0; pack = 1'b1; lreg = 1'b1; ena = 1'b1; d0 = 4'b1000;
        step();
        chk("R7 enabled capture", l0, 1'b1);
        ena = 1'b0; d0 = 4'b0000;
        step();
        chk("R7 hold while disabled", l0, 1'b1);
        mode = 2'd2; d0 = 4'b0100; d1 = 4'b0100;
        step();
        chk("R7 load ignored while disabled", l0, 1'b1);
        ena = 1'b1;
        step();
        chk("R7 load taken when enabled", l0, 1'b0);
        mode = 2'd0; pack = 1'b0;
    endtask

    task automatic t_async();
        @(negedge clk);
        mode = 2'd0; pack = 1'b1; lreg = 1'b1; ena = 1'b0; d0 = 4'b0000;
        #1; pre = 1'b1; #0.5;
        chk("R8 preset immediate", l0, 1'b1);
        @(negedge clk); pre = 1'b0; #1;
        chk("R8 preset retained", l0, 1'b1);
        clr = 1'b1; #0.5;
        chk("R8 clear immediate", l0, 1'b0);
        @(negedge clk); clr = 1'b0;
        pre = 1'b1; #1;
        chk("R8 preset again", l0, 1'b1);
        clr = 1'b1; #0.5;
        chk("R8 clear beats preset", l0, 1'b0);
        @(negedge clk); clr = 1'b0; pre = 1'b0; #1;
        chk("R8 value after release", l0, 1'b0);
        ena = 1'b1; pack = 1'b0;
    endtask

    task automatic t_counter();
        logic [1:0] exp;
        @(negedge clk);
        mode = 2'd2; ena = 1'b1; lreg = 1'b1; cin0 = 1'b1;
        rst_n = 1'b0; d0 = 4'b0000; d1 = 4'b0000;
        step();
        rst_n = 1'b1;
        chk("R10 counter cleared", l0 | l1, 1'b0);
        d0 = 4'b1010; d1 = 4'b1010; exp = 2'd0;
        for (int i = 0; i < 5; i++) begin
            step();
            exp = exp + 2'd1;
            chk("R9 up bit0", l0, exp[0]);
            chk("R9 up bit1", l1, exp[1]);
        end
        chk("R9 up carry", cout0, 1'b1);
        d0 = 4'b1000; d1 = 4'b1000; #1;
        chk("R9 down carry", cout0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step();
            exp = exp - 2'd1;
            chk("R9 down bit0", l0, exp[0]);
            chk("R9 down bit1", l1, exp[1]);
        end
        d0 = 4'b1100; d1 = 4'b1101;
        step();
        chk("R9 load bit0", l0, 1'b0);
        chk("R9 load bit1", l1, 1'b1);
        d0 = 4'b0010; d1 = 4'b0010;
        step(); step();
        chk("R9 hold bit0", l0, 1'b0);
        chk("R9 hold bit1", l1, 1'b1);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk("R10 mid-run reset bit1", l1, 1'b0);
        mode = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_cascade();
        t_arith();
        t_pack();
        t_route();
        t_enable();
        t_async();
        t_counter();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule